// File: doc/BRIEF.md
# Prioritized CPU Interrupt Arbiter

This block sits between a processor core's interrupt sources and its exception sequencer. Each of fourteen sources raises a one-cycle set strobe, which the block latches into a sticky pending vector. A source may also withdraw its request with a clear strobe. When the core asks for an evaluation, the block masks the pending vector with the current processor state. That state is external enable, critical enable, machine-check enable, hypervisor state, whether hypervisor mode exists, a partition control bit that routes external interrupts, and a hypervisor-decrementer enable. The block then grants the highest-priority deliverable source.

A grant appears one cycle after the evaluation as a single-cycle take strobe together with a 4-bit cause code. At the same clock edge the granted source's pending bit is removed, but only when that source is of a kind that clears on delivery. Level-style sources stay pending until the source clears them. The decrementer is one of these unless a mode input selects clear-on-delivery. A summary request line stays high while any pending bit is set.

Top module: `irq_prio_arb`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, `take_o`, `cause_o`, `pend_o` and `hard_req_o` are all zero.
- R2: A pulse on `set_i[k]` makes `pend_o[k]` read 1 from the next clock edge, and the bit stays set with no further pulse. A pulse on `clr_i[k]` removes it.
- R3: Cause codes follow priority order, highest first. The codes are 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 external, 5 critical external, 6 watchdog, 7 critical doorbell, 8 fixed-interval timer, 9 programmable-interval timer, 10 decrementer, 11 doorbell, 12 performance monitor, 13 thermal. The pending bit index equals the code. The lowest deliverable code wins.
- R4: Reset (code 0) is deliverable with every enable low. Machine check (code 1) is deliverable only when `me_i` is 1.
- R5: The hypervisor decrementer is deliverable only when `hdec_en_i` is 1 and either `ee_i` is 1 or `hv_state_i` is 0.
- R6: External (code 4) is deliverable when `ee_i` is 1. It is also deliverable when `hv_present_i` is 1, `hv_state_i` is 0 and `lpes0_i` is 0.
- R7: External and critical external stay pending after being taken.
- R8: Critical external, debug, watchdog and critical doorbell are gated by `ce_i`. Codes 8 to 13 are gated by `ee_i`. A masked source is not taken and stays pending.
- R9: Codes 0, 1, 2, 3, 6, 7, 8, 9, 11, 12 and 13 clear their pending bit at the edge that raises `take_o`.
- R10: The decrementer clears on delivery only when `decr_clr_mode_i` is 1. Otherwise it stays pending.
- R11: `take_o` rises only in the cycle after `eval_i` was high with a deliverable source, and lasts one cycle per evaluation. No evaluation means no take.
- R12: A pending bit that is set in the same cycle as it is cleared, by `clr_i` or by delivery, stays set.
- R13: `hard_req_o` is 1 whenever any pending bit is set. It falls only once the whole pending vector is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 14 | Per-source set strobes, bit index = cause code |
| clr_i | input | 14 | Per-source withdraw strobes |
| eval_i | input | 1 | Request one arbitration this cycle |
| ee_i | input | 1 | External enable |
| ce_i | input | 1 | Critical enable |
| me_i | input | 1 | Machine-check enable |
| hv_state_i | input | 1 | Core is in hypervisor state |
| hv_present_i | input | 1 | Hypervisor mode exists |
| lpes0_i | input | 1 | Partition control: externals stay with the current privilege |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| decr_clr_mode_i | input | 1 | Decrementer clears on delivery |
| take_o | output | 1 | One-cycle grant strobe (cause valid) |
| cause_o | output | 4 | Encoded granted cause |
| pend_o | output | 14 | Pending vector |
| hard_req_o | output | 1 | Summary request, high while anything is pending |

## Verification
The bench walks a window of pending sources down the priority list. An off-by-one or reversed encoder would then report the wrong cause. Each gate is checked with its enable low, where a wrong mask takes a source it should hold or holds one it should take. The external bypass path is checked on its own, since a design that drops it would never deliver with `ee_i` low. The sticky sources, external, critical external and the decrementer in its non-clearing mode, are checked after delivery: a design that clears them would lose a level request. A set landing in the same cycle as a clear is also checked, because a wrong resolution loses the new event.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC = 14;
  localparam int CAUSE_W = $clog2(NUM_SRC);

  // Index order is the priority order: lower index wins.
  typedef enum logic [CAUSE_W-1:0] {
    SRC_RESET  = 4'd0,
    SRC_MCHK   = 4'd1,
    SRC_DEBUG  = 4'd2,
    SRC_HDEC   = 4'd3,
    SRC_EXT    = 4'd4,
    SRC_CEXT   = 4'd5,
    SRC_WDOG   = 4'd6,
    SRC_CDBELL = 4'd7,
    SRC_FIT    = 4'd8,
    SRC_PIT    = 4'd9,
    SRC_DECR   = 4'd10,
    SRC_DBELL  = 4'd11,
    SRC_PERF   = 4'd12,
    SRC_THERM  = 4'd13
  } irq_src_e;

  typedef struct packed {
    logic ee;
    logic ce;
    logic me;
    logic hv_state;
    logic hv_present;
    logic lpes0;
    logic hdec_en;
    logic decr_clr_mode;
  } core_state_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
(
  input  core_state_t        st_i,
  output logic [NUM_SRC-1:0] deliv_en_o,
  output logic [NUM_SRC-1:0] keep_o
);
  always_comb begin
    deliv_en_o = '0;
    deliv_en_o[SRC_RESET]  = 1'b1;
    deliv_en_o[SRC_MCHK]   = st_i.me;
    deliv_en_o[SRC_DEBUG]  = st_i.ce;
    deliv_en_o[SRC_HDEC]   = st_i.hdec_en & (st_i.ee | ~st_i.hv_state);
    deliv_en_o[SRC_EXT]    = st_i.ee |
                             (st_i.hv_present & ~st_i.hv_state & ~st_i.lpes0);
    deliv_en_o[SRC_CEXT]   = st_i.ce;
    deliv_en_o[SRC_WDOG]   = st_i.ce;
    deliv_en_o[SRC_CDBELL] = st_i.ce;
    deliv_en_o[SRC_FIT]    = st_i.ee;
    deliv_en_o[SRC_PIT]    = st_i.ee;
    deliv_en_o[SRC_DECR]   = st_i.ee;
    deliv_en_o[SRC_DBELL]  = st_i.ee;
    deliv_en_o[SRC_PERF]   = st_i.ee;
    deliv_en_o[SRC_THERM]  = st_i.ee;
  end

  // Sources that remain pending after delivery.
  always_comb begin
    keep_o = '0;
    keep_o[SRC_EXT]  = 1'b1;
    keep_o[SRC_CEXT] = 1'b1;
    keep_o[SRC_DECR] = ~st_i.decr_clr_mode;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 14,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = W'(k);
    end
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] drop_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_comb begin
      pend_d[k] = set_i[k] | (pend_q[k] & ~clr_i[k] & ~drop_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[k] <= 1'b0;
      else        pend_q[k] <= pend_d[k];
    end

    assert_set_wins_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_i[k]) |-> pend_q[k]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               eval_i,
  input  logic               ee_i,
  input  logic               ce_i,
  input  logic               me_i,
  input  logic               hv_state_i,
  input  logic               hv_present_i,
  input  logic               lpes0_i,
  input  logic               hdec_en_i,
  input  logic               decr_clr_mode_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               hard_req_o
);
  logic               rst_sn;
  core_state_t        st;
  logic [NUM_SRC-1:0] deliv_en;
  logic [NUM_SRC-1:0] keep;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] ready;
  logic               any_ready;
  logic [CAUSE_W-1:0] win_idx;
  logic               grant;
  logic [NUM_SRC-1:0] grant_vec;
  logic [NUM_SRC-1:0] drop;
  logic               take_q, take_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sn)
  );

  always_comb begin
    st.ee            = ee_i;
    st.ce            = ce_i;
    st.me            = me_i;
    st.hv_state      = hv_state_i;
    st.hv_present    = hv_present_i;
    st.lpes0         = lpes0_i;
    st.hdec_en       = hdec_en_i;
    st.decr_clr_mode = decr_clr_mode_i;
  end

  irq_gate u_gate (.st_i(st), .deliv_en_o(deliv_en), .keep_o(keep));

  assign ready = pend & deliv_en;

  irq_prio_pick #(.N(NUM_SRC), .W(CAUSE_W)) u_pick (
    .req_i(ready), .any_o(any_ready), .idx_o(win_idx)
  );

  always_comb begin
    grant     = eval_i & any_ready;
    grant_vec = grant ? (NUM_SRC'(1) << win_idx) : '0;
    drop      = grant_vec & ~keep;
    take_d    = grant;
    cause_d   = grant ? win_idx : '0;
  end

  irq_pend_reg #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_sn), .set_i(set_i), .clr_i(clr_i),
    .drop_i(drop), .pend_o(pend)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      take_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      take_q  <= take_d;
      cause_q <= cause_d;
    end
  end

  assign take_o     = take_q;
  assign cause_o    = cause_q;
  assign pend_o     = pend;
  assign hard_req_o = |pend;

  assert_take_needs_eval_R11 : assert property (@(posedge clk) disable iff (!rst_sn)
    take_o |-> $past(eval_i));
  assert_reset_first_R3 : assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(eval_i) && $past(pend[SRC_RESET])) |-> (take_o && cause_o == SRC_RESET));
  assert_mchk_gate_R4 : assert property (@(posedge clk) disable iff (!rst_sn)
    (take_o && cause_o == SRC_MCHK) |-> $past(me_i));
  assert_ext_level_R7 : assert property (@(posedge clk) disable iff (!rst_sn)
    (take_o && cause_o == SRC_EXT && !$past(clr_i[SRC_EXT])) |-> pend[SRC_EXT]);
  assert_wdog_clear_R9 : assert property (@(posedge clk) disable iff (!rst_sn)
    (take_o && cause_o == SRC_WDOG && !$past(set_i[SRC_WDOG])) |-> !pend[SRC_WDOG]);
endmodule

// File: tb/irq_prio_arb_tb_top.sv
`timescale 1ns/1ps
module irq_prio_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] set_i, clr_i;
  logic        eval_i, ee_i, ce_i, me_i, hv_state_i, hv_present_i;
  logic        lpes0_i, hdec_en_i, decr_clr_mode_i;
  logic        take_o, hard_req_o;
  logic [3:0]  cause_o;
  logic [13:0] pend_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  irq_prio_arb dut_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i), .eval_i(eval_i),
    .ee_i(ee_i), .ce_i(ce_i), .me_i(me_i), .hv_state_i(hv_state_i),
    .hv_present_i(hv_present_i), .lpes0_i(lpes0_i), .hdec_en_i(hdec_en_i),
    .decr_clr_mode_i(decr_clr_mode_i), .take_o(take_o), .cause_o(cause_o),
    .pend_o(pend_o), .hard_req_o(hard_req_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_bits(input logic [13:0] m);
    set_i = m; tick(); set_i = '0;
  endtask

  task automatic clear_all();
    clr_i = '1; tick(); clr_i = '0;
  endtask

  task automatic eval1();
    eval_i = 1'b1; tick(); eval_i = 1'b0;
  endtask

  task automatic state(input logic ee, ce, me, hv, hvp, lp, hd, dm);
    ee_i = ee; ce_i = ce; me_i = me; hv_state_i = hv;
    hv_present_i = hvp; lpes0_i = lp; hdec_en_i = hd; decr_clr_mode_i = dm;
  endtask

  // expect a take of code c after an eval
  task automatic expect_take(input int c, input string req);
    eval1();
    check(take_o === 1'b1, req, int'(take_o), 1);
    check(cause_o === 4'(c), req, int'(cause_o), c);
  endtask

  task automatic expect_none(input int b, input string req);
    eval1();
    check(take_o === 1'b0, req, int'(take_o), 0);
    check(pend_o[b] === 1'b1, req, int'(pend_o[b]), 1);
  endtask

  task automatic t_reset();
    check(take_o === 1'b0 && pend_o === '0 && hard_req_o === 1'b0, "R1", int'(pend_o), 0);
  endtask

  task automatic t_pending();
    state(0,0,0,0,0,1,0,0);
    set_bits(14'h0100);
    check(pend_o === 14'h0100, "R2", int'(pend_o), 'h100);
    tick(); tick();
    check(pend_o === 14'h0100, "R2", int'(pend_o), 'h100);
    clr_i = 14'h0100; tick(); clr_i = '0;
    check(pend_o === '0, "R2", int'(pend_o), 0);
  endtask

  task automatic t_priority();
    state(1,1,1,0,0,1,1,1);
    for (int i = 0; i < 14; i++) begin
      clear_all();
      set_bits(14'h3fff & ~((14'd1 << i) - 14'd1));
      expect_take(i, "R3");
    end
    clear_all();
  endtask

  task automatic t_reset_mchk();
    state(0,0,0,0,0,1,0,0);
    set_bits(14'h0001);
    expect_take(0, "R4");
    check(pend_o[0] === 1'b0, "R9", int'(pend_o[0]), 0);
    set_bits(14'h0002);
    expect_none(1, "R4");
    me_i = 1'b1;
    expect_take(1, "R4");
    check(pend_o[1] === 1'b0, "R9", int'(pend_o[1]), 0);
  endtask

  task automatic t_hdec();
    state(1,0,0,0,0,1,0,0);
    set_bits(14'h0008);
    expect_none(3, "R5");
    state(0,0,0,1,0,1,1,0);
    expect_none(3, "R5");
    hv_state_i = 1'b0;
    expect_take(3, "R5");
    check(pend_o[3] === 1'b0, "R9", int'(pend_o[3]), 0);
  endtask

  task automatic t_ext();
    state(0,0,0,0,1,1,0,0);
    set_bits(14'h0010);
    expect_none(4, "R6");
    state(0,0,0,0,0,0,0,0);
    expect_none(4, "R6");
    state(0,0,0,1,1,0,0,0);
    expect_none(4, "R6");
    state(0,0,0,0,1,0,0,0);
    expect_take(4, "R6");
    check(pend_o[4] === 1'b1, "R7", int'(pend_o[4]), 1);
    state(1,0,0,1,0,1,0,0);
    expect_take(4, "R6");
    check(pend_o[4] === 1'b1, "R7", int'(pend_o[4]), 1);
    clear_all();
  endtask

  task automatic t_critical();
    state(1,0,0,0,0,1,0,0);
    set_bits(14'h0020);
    expect_none(5, "R8");
    ce_i = 1'b1;
    expect_take(5, "R8");
    check(pend_o[5] === 1'b1, "R7", int'(pend_o[5]), 1);
    clear_all();
    state(1,0,0,0,0,1,0,0);
    set_bits(14'h0040);
    expect_none(6, "R8");
    ce_i = 1'b1;
    expect_take(6, "R8");
    check(pend_o[6] === 1'b0, "R9", int'(pend_o[6]), 0);
    state(0,1,0,0,0,1,0,0);
    set_bits(14'h0100);
    expect_none(8, "R8");
    ee_i = 1'b1;
    expect_take(8, "R8");
    check(pend_o[8] === 1'b0, "R9", int'(pend_o[8]), 0);
  endtask

  task automatic t_decr();
    state(1,0,0,0,0,1,0,0);
    set_bits(14'h0400);
    expect_take(10, "R10");
    check(pend_o[10] === 1'b1, "R10", int'(pend_o[10]), 1);
    decr_clr_mode_i = 1'b1;
    expect_take(10, "R10");
    check(pend_o[10] === 1'b0, "R10", int'(pend_o[10]), 0);
  endtask

  task automatic t_strobe();
    state(1,1,1,0,0,1,1,1);
    set_bits(14'h2000);
    tick(); tick();
    check(take_o === 1'b0, "R11", int'(take_o), 0);
    expect_take(13, "R11");
    tick();
    check(take_o === 1'b0, "R11", int'(take_o), 0);
  endtask

  task automatic t_same_cycle();
    state(1,1,1,0,0,1,1,1);
    set_bits(14'h0800);
    set_i = 14'h0800; clr_i = 14'h0800; tick(); set_i = '0; clr_i = '0;
    check(pend_o[11] === 1'b1, "R12", int'(pend_o[11]), 1);
    set_i = 14'h0800; eval_i = 1'b1; tick(); set_i = '0; eval_i = 1'b0;
    check(take_o === 1'b1 && cause_o === 4'd11, "R12", int'(cause_o), 11);
    check(pend_o[11] === 1'b1, "R12", int'(pend_o[11]), 1);
    clear_all();
  endtask

  task automatic t_summary();
    state(1,1,1,0,0,1,1,1);
    set_bits(14'h1080);
    check(hard_req_o === 1'b1, "R13", int'(hard_req_o), 1);
    expect_take(7, "R13");
    check(hard_req_o === 1'b1, "R13", int'(hard_req_o), 1);
    expect_take(12, "R13");
    check(hard_req_o === 1'b0, "R13", int'(hard_req_o), 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; set_i = '0; clr_i = '0; eval_i = 1'b0;
    state(0,0,0,0,0,1,0,0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    repeat (3) tick();
    t_pending();
    t_priority();
    t_reset_mchk();
    t_hdec();
    t_ext();
    t_critical();
    t_decr();
    t_strobe();
    t_same_cycle();
    t_summary();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule